// File: doc/BRIEF.md
# Cascaded One-Shot Down Timer

This block is a down-counting timer built from two cascaded stages. A prescaler steps down on every active count-source edge. Each time it passes through zero it steps the main counter once. Both stages reload from their own writable reload registers. The count source is a single-cycle clock enable inside the system clock domain, so the whole block runs on one clock.

Software controls the timer with a level start request, a level forced-stop bit, a mode bit, and two single-cycle strobes that launch or abort a one-shot. Two status flags report the state: one shows that counting is in progress, the other that a one-shot is live. These flags follow the requests only on count-source edges, so they lag the request. Forced stop is the one exception and acts at once.

In one-shot mode the counters run only while a shot is live. The output pin is high for the length of the shot. A main-counter underflow ends the shot. An abort, or dropping the start request, restores both counters from their reload values instead of leaving them frozen. Every main-counter underflow raises a one-clock interrupt pulse. The two counters can be read as separate bytes with no snapshot, so a read taken while counting may mix two counts.

Top module: `cascade_shot_timer`

## Requirements
- R1: After reset, `running`, `shot_active`, `irq` and `tmr_out` are 0, and both counters and both reload values are 0.
- R2: While counting, the prescaler decrements on each `cnt_en` cycle. From 0 it reloads and emits an underflow. Each prescaler underflow decrements the main counter, which also reloads from 0.
- R3: When `run_req` rises while stopped, `running` goes to 1 at the second `cnt_en` edge that follows. The first decrement happens on the next `cnt_en` edge after that.
- R4: When `run_req` falls while counting, `running` goes to 0 at the second `cnt_en` edge that follows, and that edge still counts. In timer mode (`oneshot_mode`=0) the counters then hold their values.
- R5: While `force_halt` is 1, no counter steps. `running` reads 0 from the clock after it is asserted, with no wait for `cnt_en`.
- R6: A reload write while `running` is 0 also loads the counter. A reload write while `running` is 1 changes only the reload value, and the counter takes that value at its next underflow.
- R7: A main-counter underflow gives a one-clock `irq` pulse in the clock after the `cnt_en` edge on which it happened.
- R8: In one-shot mode (`oneshot_mode`=1), a `shot_go` strobe sets `shot_active` at the second `cnt_en` edge after the strobe. Counters step only while `shot_active` is 1, and `tmr_out` equals `shot_active`.
- R9: In one-shot mode, a main-counter underflow clears `shot_active` and reloads both counters.
- R10: In one-shot mode, a `shot_kill` strobe clears `shot_active` at the second `cnt_en` edge after the strobe. On that same edge both counters are loaded from their reload values.
- R11: In one-shot mode, when `running` falls after `run_req` is cleared, both counters are loaded from their reload values and `shot_active` is cleared on the same edge.
- R12: Apart from `force_halt`, `running` and `shot_active` change only on cycles where `cnt_en` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count-source enable, one clock per active edge |
| run_req | input | 1 | Start request (level) |
| force_halt | input | 1 | Forced stop (level), acts at once |
| oneshot_mode | input | 1 | 0 = timer mode, 1 = one-shot mode |
| shot_go | input | 1 | One-shot launch strobe |
| shot_kill | input | 1 | One-shot abort strobe |
| pre_wr | input | 1 | Prescaler reload write strobe |
| pre_wdata | input | 8 | Prescaler reload value |
| main_wr | input | 1 | Main reload write strobe |
| main_wdata | input | 8 | Main reload value |
| pre_count | output | 8 | Current prescaler count |
| main_count | output | 8 | Current main counter value |
| running | output | 1 | Counting-status flag |
| shot_active | output | 1 | One-shot live flag |
| irq | output | 1 | Underflow interrupt pulse |
| tmr_out | output | 1 | One-shot output pin |

## Verification
The assertions watch, on every cycle, that the status flags move only on count-source cycles or under forced stop, that forced stop clears the counting flag in the next clock, that the prescaler never moves while stopped unless it is written or restored, and that every interrupt pulse follows a count-source cycle. The exact two-edge lag of start, stop, launch and abort, the cascade arithmetic, and the deferred use of a reload written while counting can only be shown by the bench scenarios. The same holds for the restore-on-stop in one-shot mode compared with the freeze in timer mode.

// File: rtl/pst_pkg.sv
package pst_pkg;
  typedef struct packed {
    logic go;
    logic kill;
  } shot_cmd_t;

  localparam shot_cmd_t SHOT_NONE = '{go: 1'b0, kill: 1'b0};
  localparam shot_cmd_t SHOT_GO   = '{go: 1'b1, kill: 1'b0};
  localparam shot_cmd_t SHOT_KILL = '{go: 1'b0, kill: 1'b1};
endpackage

// File: rtl/pst_rst_sync.sv
module pst_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pst_down_stage.sv
module pst_down_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         load_now,
  input  logic         restore,
  output logic [W-1:0] cnt,
  output logic         uf
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_q, cnt_d, rld_q, rld_d;

  always_comb begin
    rld_d = wr ? wdata : rld_q;
    cnt_d = cnt_q;
    if (restore)               cnt_d = rld_q;
    else if (wr && load_now)   cnt_d = wdata;
    else if (step)             cnt_d = (cnt_q == ZERO) ? rld_q : cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
      rld_q <= ZERO;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
    end
  end

  assign cnt = cnt_q;
  assign uf  = step && (cnt_q == ZERO);
endmodule

// File: rtl/pst_stat_sync.sv
module pst_stat_sync
  import pst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_en,
  input  logic run_req,
  input  logic force_halt,
  input  logic shot_go,
  input  logic shot_kill,
  input  logic shot_done,
  output logic running,
  output logic shot_active,
  output logic stop_evt,
  output logic kill_evt
);
  logic      req_q, req_d, run_q, run_d, act_q, act_d;
  shot_cmd_t pend_q, pend_d, stg_q, stg_d;

  assign stop_evt = cnt_en && run_q && !req_q && !force_halt;
  assign kill_evt = cnt_en && stg_q.kill && !force_halt;

  always_comb begin
    req_d  = req_q;
    run_d  = run_q;
    act_d  = act_q;
    pend_d = pend_q;
    stg_d  = stg_q;
    if (shot_go)        pend_d = SHOT_GO;
    else if (shot_kill) pend_d = SHOT_KILL;
    else if (cnt_en)    pend_d = SHOT_NONE;
    if (force_halt) begin
      req_d  = 1'b0;
      run_d  = 1'b0;
      act_d  = 1'b0;
      pend_d = SHOT_NONE;
      stg_d  = SHOT_NONE;
    end else if (cnt_en) begin
      req_d = run_req;
      run_d = req_q;
      stg_d = pend_q;
      if (shot_done || stg_q.kill || stop_evt) act_d = 1'b0;
      else if (stg_q.go)                       act_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      run_q  <= 1'b0;
      act_q  <= 1'b0;
      pend_q <= SHOT_NONE;
      stg_q  <= SHOT_NONE;
    end else begin
      req_q  <= req_d;
      run_q  <= run_d;
      act_q  <= act_d;
      pend_q <= pend_d;
      stg_q  <= stg_d;
    end
  end

  assign running     = run_q;
  assign shot_active = act_q;

  // R12: the counting flag rises only after a count-source cycle
  a_r12_run_rise_on_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(cnt_en));
  // R12: the counting flag falls only on a count-source cycle or under forced stop
  a_r12_run_fall_on_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> ($past(cnt_en) || $past(force_halt)));
  // R8 / R12: the shot flag rises only after a count-source cycle
  a_r8_shot_rise_on_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shot_active) |-> $past(cnt_en));
  // R5: forced stop clears the counting flag in the next clock
  a_r5_halt_next_clock: assert property (@(posedge clk) disable iff (!rst_n)
    force_halt |=> !running);
endmodule

// File: rtl/cascade_shot_timer.sv
module cascade_shot_timer #(
  parameter int PRE_W  = 8,
  parameter int MAIN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              run_req,
  input  logic              force_halt,
  input  logic              oneshot_mode,
  input  logic              shot_go,
  input  logic              shot_kill,
  input  logic              pre_wr,
  input  logic [PRE_W-1:0]  pre_wdata,
  input  logic              main_wr,
  input  logic [MAIN_W-1:0] main_wdata,
  output logic [PRE_W-1:0]  pre_count,
  output logic [MAIN_W-1:0] main_count,
  output logic              running,
  output logic              shot_active,
  output logic              irq,
  output logic              tmr_out
);
  logic rst_n_s;
  logic stop_evt, kill_evt, restore;
  logic pre_step, pre_uf, main_uf, shot_done;
  logic irq_q, irq_d;

  pst_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  pst_stat_sync u_stat (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .cnt_en      (cnt_en),
    .run_req     (run_req),
    .force_halt  (force_halt),
    .shot_go     (shot_go),
    .shot_kill   (shot_kill),
    .shot_done   (shot_done),
    .running     (running),
    .shot_active (shot_active),
    .stop_evt    (stop_evt),
    .kill_evt    (kill_evt)
  );

  assign restore   = oneshot_mode && (stop_evt || kill_evt);
  assign pre_step  = cnt_en && running && !force_halt && !restore
                     && (!oneshot_mode || shot_active);
  assign shot_done = oneshot_mode && main_uf;

  pst_down_stage #(.W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .step     (pre_step),
    .wr       (pre_wr),
    .wdata    (pre_wdata),
    .load_now (!running),
    .restore  (restore),
    .cnt      (pre_count),
    .uf       (pre_uf)
  );

  pst_down_stage #(.W(MAIN_W)) u_main (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .step     (pre_uf),
    .wr       (main_wr),
    .wdata    (main_wdata),
    .load_now (!running),
    .restore  (restore),
    .cnt      (main_count),
    .uf       (main_uf)
  );

  always_comb irq_d = main_uf;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) irq_q <= 1'b0;
    else          irq_q <= irq_d;
  end

  assign irq     = irq_q;
  assign tmr_out = oneshot_mode && shot_active;

  // R7: every interrupt pulse follows a count-source cycle
  a_r7_irq_after_cs: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq |-> $past(cnt_en));
  // R2: the prescaler moves without a write or restore only while counting
  a_r2_pre_moves_when_running: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!$stable(pre_count) && !$past(pre_wr) && !$past(restore)) |-> $past(running));
  // R5: no count step while forced stop is held
  a_r5_no_step_in_halt: assert property (@(posedge clk) disable iff (!rst_n_s)
    (force_halt && !pre_wr && !main_wr) |=> ($stable(pre_count) && $stable(main_count)));
endmodule

// File: tb/test_cascade_shot_timer.sv
module test_cascade_shot_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0, run_req = 1'b0, force_halt = 1'b0, oneshot_mode = 1'b0;
  logic       shot_go = 1'b0, shot_kill = 1'b0, pre_wr = 1'b0, main_wr = 1'b0;
  logic [7:0] pre_wdata = 8'd0, main_wdata = 8'd0;
  logic [7:0] pre_count, main_count;
  logic       running, shot_active, irq, tmr_out;
  int         n_chk = 0, n_bad = 0, irq_cnt = 0;

  always #4 clk = ~clk;

  cascade_shot_timer i_cascade_shot_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .run_req(run_req),
    .force_halt(force_halt), .oneshot_mode(oneshot_mode), .shot_go(shot_go),
    .shot_kill(shot_kill), .pre_wr(pre_wr), .pre_wdata(pre_wdata),
    .main_wr(main_wr), .main_wdata(main_wdata), .pre_count(pre_count),
    .main_count(main_count), .running(running), .shot_active(shot_active),
    .irq(irq), .tmr_out(tmr_out)
  );

  always @(negedge clk) if (rst_n && irq) irq_cnt = irq_cnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cs();
    @(negedge clk) cnt_en = 1'b1;
    @(negedge clk) cnt_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic cs_n(input int n);
    for (int i = 0; i < n; i++) cs();
  endtask

  task automatic wr_pre(input logic [7:0] v);
    @(negedge clk) begin pre_wr = 1'b1; pre_wdata = v; end
    @(negedge clk) pre_wr = 1'b0;
  endtask

  task automatic wr_main(input logic [7:0] v);
    @(negedge clk) begin main_wr = 1'b1; main_wdata = v; end
    @(negedge clk) main_wr = 1'b0;
  endtask

  task automatic strobe_go();
    @(negedge clk) shot_go = 1'b1;
    @(negedge clk) shot_go = 1'b0;
  endtask

  task automatic strobe_kill();
    @(negedge clk) shot_kill = 1'b1;
    @(negedge clk) shot_kill = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 running", running, 0);
    chk("R1 shot_active", shot_active, 0);
    chk("R1 tmr_out", tmr_out, 0);
    chk("R1 pre_count", pre_count, 0);
    chk("R1 main_count", main_count, 0);
    chk("R1 irq", irq_cnt, 0);
  endtask

  task automatic t_load_stopped();
    wr_pre(8'd3);
    wr_main(8'd2);
    chk("R6 stopped pre load", pre_count, 3);
    chk("R6 stopped main load", main_count, 2);
  endtask

  task automatic t_start_lag();
    @(negedge clk) run_req = 1'b1;
    cs();
    chk("R3 flag still 0 after first edge", running, 0);
    cs();
    chk("R3 flag 1 after second edge", running, 1);
    chk("R3 no step on flag edge", pre_count, 3);
    cs();
    chk("R3 first step", pre_count, 2);
  endtask

  task automatic t_cascade();
    cs_n(10);
    chk("R2 pre before wrap", pre_count, 0);
    chk("R2 main before wrap", main_count, 0);
    chk("R7 no irq yet", irq_cnt, 0);
    cs();
    chk("R2 pre reload", pre_count, 3);
    chk("R2 main reload", main_count, 2);
    chk("R7 one irq pulse", irq_cnt, 1);
  endtask

  task automatic t_stop_lag();
    @(negedge clk) run_req = 1'b0;
    cs();
    chk("R4 flag still 1", running, 1);
    chk("R4 counting continues", pre_count, 2);
    cs();
    chk("R4 flag 0 after second edge", running, 0);
    chk("R4 last step", pre_count, 1);
    cs();
    chk("R4 frozen in timer mode", pre_count, 1);
    chk("R4 main frozen", main_count, 2);
  endtask

  task automatic t_write_running();
    @(negedge clk) run_req = 1'b1;
    cs_n(2);
    chk("R6 running again", running, 1);
    wr_pre(8'd5);
    chk("R6 write while running keeps count", pre_count, 1);
    cs();
    chk("R6 count continues", pre_count, 0);
    cs();
    chk("R6 new reload at underflow", pre_count, 5);
    chk("R6 main stepped", main_count, 1);
  endtask

  task automatic t_force_halt();
    @(negedge clk) force_halt = 1'b1;
    @(negedge clk);
    chk("R5 flag cleared next clock", running, 0);
    cs();
    chk("R5 no step while halted", pre_count, 5);
    @(negedge clk) begin force_halt = 1'b0; run_req = 1'b0; end
    cs();
    chk("R5 stays stopped", running, 0);
    chk("R5 count held", pre_count, 5);
  endtask

  task automatic t_oneshot_run();
    @(negedge clk) oneshot_mode = 1'b1;
    wr_pre(8'd1);
    wr_main(8'd1);
    @(negedge clk) run_req = 1'b1;
    cs_n(2);
    chk("R8 running", running, 1);
    cs();
    chk("R8 no step without shot", pre_count, 1);
    strobe_go();
    cs();
    chk("R8 shot flag lags", shot_active, 0);
    cs();
    chk("R8 shot flag set", shot_active, 1);
    chk("R8 pin high", tmr_out, 1);
    chk("R8 no step on flag edge", pre_count, 1);
    cs_n(3);
    chk("R8 mid-shot pre", pre_count, 0);
    chk("R8 mid-shot main", main_count, 0);
    cs();
    chk("R9 shot ended", shot_active, 0);
    chk("R9 pin low", tmr_out, 0);
    chk("R9 pre reload", pre_count, 1);
    chk("R9 main reload", main_count, 1);
    chk("R7 irq at shot end", irq_cnt, 2);
  endtask

  task automatic t_kill();
    strobe_go();
    cs_n(2);
    chk("R10 shot live", shot_active, 1);
    cs();
    chk("R10 stepping", pre_count, 0);
    strobe_kill();
    cs();
    chk("R10 flag lags kill", shot_active, 1);
    chk("R10 step before kill", main_count, 0);
    cs();
    chk("R10 shot cleared", shot_active, 0);
    chk("R10 pre restored", pre_count, 1);
    chk("R10 main restored", main_count, 1);
    chk("R10 no irq from kill", irq_cnt, 2);
  endtask

  task automatic t_run_clear_oneshot();
    strobe_go();
    cs_n(2);
    chk("R11 shot live", shot_active, 1);
    cs();
    @(negedge clk) run_req = 1'b0;
    cs();
    chk("R11 still counting", main_count, 0);
    cs();
    chk("R11 stopped", running, 0);
    chk("R11 shot cleared", shot_active, 0);
    chk("R11 pre restored", pre_count, 1);
    chk("R11 main restored", main_count, 1);
    chk("R11 no irq", irq_cnt, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_load_stopped();
    t_start_lag();
    t_cascade();
    t_stop_lag();
    t_write_running();
    t_force_halt();
    t_oneshot_run();
    t_kill();
    t_run_clear_oneshot();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule